// File: doc/BRIEF.md
# Stereo PDM microphone front end

This block drives the bit clock of two pulse-density-modulated microphones that share a single data wire and turns their interleaved one-bit output into a pair of signed 16-bit PCM samples, one pair per audio frame. The bit clock is generated from the system clock at 64 periods per frame and is realigned at every frame strobe. The shared data wire is sampled once near the end of each clock phase. Each sample is sent to the left or right path depending on the phase it came from and a run-time polarity setting.

Each path is a third-order cascaded integrator-comb decimator with a ratio of 64. The integrators run at the per-channel bit rate and the combs run at the frame rate. Its output is offset and scaled so that ones-density maps linearly onto the signed range. When the block is disabled, the microphone clock stops low and the filters are cleared. When it is enabled again, it restarts cleanly on the next frame strobe.

Top module: `pdm_stereo_frontend`

## Requirements
- R1: The microphone clock has a period of 2*HALF_DIV system cycles (4 with the defaults). It goes high on the clock edge that takes a frame strobe, and a frame of 256 cycles holds exactly 64 rising edges and 128 high cycles.
- R2: While `enable` is 0, `mic_clk` is low from the next cycle on. After `enable` returns to 1, it stays low until a frame strobe is taken.
- R3: With `polarity` = 1, bits sampled during the high phase of `mic_clk` feed the left output, and bits sampled during the low phase feed the right output.
- R4: With `polarity` = 0, the high phase feeds the right output and the low phase feeds the left output.
- R5: `polarity` is sampled only on a frame strobe. A change in the middle of a frame leaves the routing of that frame's remaining bits unchanged.
- R6: In steady state, after three full frames of a pattern, a channel's ones-density maps onto the output as follows: 0% gives -32768, 25% gives -16384, 50% gives 0, 75% gives 16384, and 100% gives 32767 (saturated).
- R7: `pcm_valid` is high for exactly one cycle, in the cycle after an enabled frame strobe that ends a complete frame. `pcm_left` and `pcm_right` change only in that cycle.
- R8: Deasserting `enable` clears the filters and stops `pcm_valid`. After re-enable, the first valid comes on the second frame strobe. From cleared state, one frame of all ones yields -21328.
- R9: During reset, `mic_clk`, `pcm_valid`, `pcm_left` and `pcm_right` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe at the audio frame rate |
| enable | input | 1 | Runs the microphone clock and the filters |
| polarity | input | 1 | Selects which clock phase feeds which channel |
| pdm_data | input | 1 | Shared one-bit data line from both microphones |
| mic_clk | output | 1 | Bit clock to the microphones |
| pcm_left | output | 16 | Signed left-channel sample |
| pcm_right | output | 16 | Signed right-channel sample |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The last low-phase bit of a frame is captured on the same edge that takes the frame strobe. On that edge the combs dump and the new polarity is latched. The capture therefore has to reach the correct channel under the old routing, while the dump and the routing switch happen at once. The bench keeps its frame period equal to the natural clock period so that this collision happens on every frame. It flips polarity in the middle of a frame while the two channels carry opposite full-scale streams. Any misrouted or lost bit at that edge moves an output away from exact full scale, and that is what the check looks for.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;

  // Number of microphone clock periods in one audio frame.
  localparam int MIC_PER_FRAME = 64;

  // Order of the decimating filter.
  localparam int CIC_ORDER = 3;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // Picks the channel for a sample from the phase it was taken in and the
  // latched polarity: with polarity 1 the high phase is left.
  function automatic chan_e phase_to_chan(input logic phase_high, input logic pol);
    return (phase_high == pol) ? CH_LEFT : CH_RIGHT;
  endfunction

endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic frame_stb,
  output logic mic_clk,
  output logic cap_stb,
  output logic cap_high
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic             run_q, run_d;
  logic             clk_q, clk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    clk_d = clk_q;
    cnt_d = cnt_q;
    if (!enable) begin
      run_d = 1'b0;
      clk_d = 1'b0;
      cnt_d = '0;
    end else if (frame_stb) begin
      run_d = 1'b1;
      clk_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        clk_d = ~clk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      clk_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      clk_q <= clk_d;
      cnt_q <= cnt_d;
    end
  end

  // Sample in the last system cycle of each phase, just before the opposite edge.
  assign cap_stb  = enable && run_q && (cnt_q == LAST);
  assign cap_high = clk_q;
  assign mic_clk  = clk_q;

endmodule

// File: rtl/pdm_cic3.sv
module pdm_cic3 #(
  parameter int LOG_R = 6,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    bit_en,
  input  logic                    bit_in,
  input  logic                    dump,
  output logic signed [OUT_W-1:0] pcm
);

  import pdm_fe_pkg::*;

  localparam int ORDER = CIC_ORDER;
  localparam int GROWTH = ORDER * LOG_R;
  localparam int ACC_W = GROWTH + 1;
  localparam int SH = GROWTH - OUT_W;
  localparam logic signed [ACC_W:0] OFFSET = (ACC_W+1)'(1 << (GROWTH - 1));
  localparam logic signed [ACC_W:0] HI = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] LO = ~HI;

  logic [ACC_W-1:0] integ_q [ORDER];
  logic [ACC_W-1:0] integ_d [ORDER];
  logic [ACC_W-1:0] integ_n [ORDER];
  logic [ACC_W-1:0] dly_q   [ORDER];
  logic [ACC_W-1:0] dly_d   [ORDER];
  logic [ACC_W-1:0] stage;
  logic [ACC_W-1:0] comb_v;
  logic signed [ACC_W:0] ys, ysh;
  logic signed [OUT_W-1:0] pcm_q, pcm_d, sat_v;

  always_comb begin
    stage = {{(ACC_W-1){1'b0}}, bit_in};
    for (int i = 0; i < ORDER; i++) begin
      integ_n[i] = integ_q[i] + stage;
      stage      = integ_n[i];
    end
    // The comb sees this cycle's bit when a capture and a dump coincide.
    comb_v = bit_en ? integ_n[ORDER-1] : integ_q[ORDER-1];
    for (int i = 0; i < ORDER; i++) begin
      dly_d[i] = dump ? comb_v : dly_q[i];
      comb_v   = comb_v - dly_q[i];
    end
    ys  = $signed({1'b0, comb_v}) - OFFSET;
    ysh = ys >>> SH;
    if (ysh > HI)      sat_v = HI[OUT_W-1:0];
    else if (ysh < LO) sat_v = LO[OUT_W-1:0];
    else               sat_v = ysh[OUT_W-1:0];

    pcm_d = dump ? sat_v : pcm_q;
    for (int i = 0; i < ORDER; i++) begin
      integ_d[i] = bit_en ? integ_n[i] : integ_q[i];
    end
    if (clear) begin
      for (int i = 0; i < ORDER; i++) begin
        integ_d[i] = '0;
        dly_d[i]   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ORDER; i++) begin
        integ_q[i] <= '0;
        dly_q[i]   <= '0;
      end
      pcm_q <= '0;
    end else begin
      for (int i = 0; i < ORDER; i++) begin
        integ_q[i] <= integ_d[i];
        dly_q[i]   <= dly_d[i];
      end
      pcm_q <= pcm_d;
    end
  end

  assign pcm = pcm_q;

endmodule

// File: rtl/pdm_stereo_frontend.sv
module pdm_stereo_frontend #(
  parameter int HALF_DIV = 2,
  parameter int RATIO    = pdm_fe_pkg::MIC_PER_FRAME,
  parameter int OUT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_stb,
  input  logic                    enable,
  input  logic                    polarity,
  input  logic                    pdm_data,
  output logic                    mic_clk,
  output logic signed [OUT_W-1:0] pcm_left,
  output logic signed [OUT_W-1:0] pcm_right,
  output logic                    pcm_valid
);

  import pdm_fe_pkg::*;

  localparam int LOG_R = $clog2(RATIO);
  localparam int NCH = 2;

  logic cap_stb, cap_high;
  logic pol_q, pol_d;
  logic primed_q, primed_d;
  logic valid_q, valid_d;
  chan_e cap_ch;
  logic [NCH-1:0] ch_en;
  logic signed [OUT_W-1:0] ch_pcm [NCH];

  pdm_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .frame_stb(frame_stb),
    .mic_clk  (mic_clk),
    .cap_stb  (cap_stb),
    .cap_high (cap_high)
  );

  always_comb begin
    // The routing for the new frame is taken at the strobe only.
    pol_d    = frame_stb ? polarity : pol_q;
    primed_d = enable ? (primed_q | frame_stb) : 1'b0;
    valid_d  = enable && frame_stb && primed_q;
    cap_ch   = phase_to_chan(cap_high, pol_q);
    for (int c = 0; c < NCH; c++) begin
      ch_en[c] = cap_stb && (cap_ch == chan_e'(c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q    <= 1'b1;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      pol_q    <= pol_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pdm_cic3 #(.LOG_R(LOG_R), .OUT_W(OUT_W)) u_cic (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!enable),
      .bit_en(ch_en[c]),
      .bit_in(pdm_data),
      .dump  (valid_d),
      .pcm   (ch_pcm[c])
    );
  end

  assign pcm_left  = ch_pcm[CH_LEFT];
  assign pcm_right = ch_pcm[CH_RIGHT];
  assign pcm_valid = valid_q;

endmodule

// File: rtl/pdm_fe_chk.sv
module pdm_fe_chk #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    frame_stb,
  input logic                    mic_clk,
  input logic                    pcm_valid,
  input logic signed [OUT_W-1:0] pcm_left,
  input logic signed [OUT_W-1:0] pcm_right
);

  // R2
  clk_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mic_clk);

  // R2
  clk_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mic_clk) |-> $past(enable));

  // R7
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  // R7
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> $past(frame_stb && enable));

  // R7
  pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));

endmodule

bind pdm_stereo_frontend pdm_fe_chk #(.OUT_W(OUT_W)) u_fe_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .frame_stb(frame_stb),
  .mic_clk  (mic_clk),
  .pcm_valid(pcm_valid),
  .pcm_left (pcm_left),
  .pcm_right(pcm_right)
);

// File: tb/test_pdm_stereo_frontend.sv
module test_pdm_stereo_frontend;

  localparam int HALF = 2;
  localparam int FRAME_CYC = 2 * HALF * 64;
  localparam int NVEC = 6;

  typedef struct packed {
    logic       pol;
    logic [3:0] lp;
    logic [3:0] rp;
    int         el;
    int         er;
  } vec_t;

  // Patterns repeat every 4 microphone periods: 0000=0%, 0001=25%, 0101=50%, 0111=75%, 1111=100%.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'b1111, 4'b0000,  32767, -32768},  // R3
    '{1'b0, 4'b1111, 4'b0000,  32767, -32768},  // R4
    '{1'b1, 4'b0101, 4'b0001,      0, -16384},  // R3 R6
    '{1'b0, 4'b0111, 4'b0101,  16384,      0},  // R4 R6
    '{1'b0, 4'b0000, 4'b1111, -32768,  32767},  // R4 R6
    '{1'b1, 4'b0001, 4'b0111, -16384,  16384}   // R3 R6
  };

  logic clk, rst_n, frame_stb, enable, polarity, pdm_data;
  logic mic_clk, pcm_valid;
  logic signed [15:0] pcm_left, pcm_right;

  int total, bad;
  logic [3:0] lpat, rpat;
  logic pol_eff, pol_pend, mic_prev;
  int kidx, fcnt;

  pdm_stereo_frontend #(.HALF_DIV(HALF)) i_pdm_stereo_frontend (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .enable(enable),
    .polarity(polarity), .pdm_data(pdm_data), .mic_clk(mic_clk),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Frame strobe and microphone model, all driven at the falling edge.
  initial begin
    frame_stb = 1'b0; pdm_data = 1'b0; pol_eff = 1'b1; pol_pend = 1'b1;
    mic_prev = 1'b0; kidx = 0; fcnt = 0;
    forever begin
      @(negedge clk);
      if (frame_stb) pol_eff = pol_pend;
      if (mic_clk && !mic_prev) kidx++;
      mic_prev = mic_clk;
      if (mic_clk == pol_eff) pdm_data = lpat[kidx & 3];
      else                    pdm_data = rpat[kidx & 3];
      fcnt = (fcnt + 1) % FRAME_CYC;
      frame_stb = (fcnt == 0);
      if (frame_stb) pol_pend = polarity;
    end
  end

  task automatic wait_valid(input string req);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pcm_valid && n < 2 * FRAME_CYC);
    if (!pcm_valid) check(req, 0, 1);
  endtask

  task automatic drive_at_posedge();
    @(posedge clk);
    #2;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; enable = 1'b1; polarity = 1'b1; lpat = 4'b1111; rpat = 4'b0000;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 mic_clk", int'(mic_clk), 0);
    check("R9 pcm_valid", int'(pcm_valid), 0);
    check("R9 pcm_left", int'(pcm_left), 0);
    check("R9 pcm_right", int'(pcm_right), 0);
    drive_at_posedge();
    rst_n = 1'b1;

    // Vector table: steady-state routing and density mapping
    for (int v = 0; v < NVEC; v++) begin
      drive_at_posedge();
      polarity = VECS[v].pol; lpat = VECS[v].lp; rpat = VECS[v].rp;
      for (int w = 0; w < 5; w++) wait_valid("R7 valid");
      check($sformatf("R6 vec%0d left", v), int'(pcm_left), VECS[v].el);
      check($sformatf("R6 vec%0d right", v), int'(pcm_right), VECS[v].er);
    end

    // R1 clock period and alignment to the frame
    wait_valid("R7 valid");
    check("R1 high after strobe", int'(mic_clk), 1);
    begin
      int rises, highs, vcount;
      logic prev;
      rises = 0; highs = 0; vcount = 0; prev = 1'b1;
      for (int i = 0; i < FRAME_CYC; i++) begin
        @(negedge clk);
        if (mic_clk && !prev) rises++;
        if (mic_clk) highs++;
        if (pcm_valid) vcount++;
        prev = mic_clk;
      end
      check("R1 rises per frame", rises, 64);
      check("R1 high cycles per frame", highs, 128);
      check("R7 one valid per frame", vcount, 1);
    end
    check("R7 valid width", int'(pcm_valid), 1);
    @(negedge clk);
    check("R7 valid width", int'(pcm_valid), 0);

    // R5 polarity flip in mid-frame with opposite full-scale channels
    drive_at_posedge();
    polarity = 1'b1; lpat = 4'b1111; rpat = 4'b0000;
    for (int w = 0; w < 4; w++) wait_valid("R7 valid");
    repeat (100) @(negedge clk);
    drive_at_posedge();
    polarity = 1'b0;
    for (int w = 0; w < 3; w++) begin
      wait_valid("R7 valid");
      check("R5 left after flip", int'(pcm_left), 32767);
      check("R5 right after flip", int'(pcm_right), -32768);
    end

    // R2 and R8: disable, then re-enable in mid-frame
    drive_at_posedge();
    polarity = 1'b1;
    for (int w = 0; w < 2; w++) wait_valid("R7 valid");
    repeat (70) @(negedge clk);
    drive_at_posedge();
    enable = 1'b0;
    begin
      int highs, vcount;
      highs = 0; vcount = 0;
      @(negedge clk);
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (mic_clk) highs++;
        if (pcm_valid) vcount++;
      end
      check("R2 clock low while disabled", highs, 0);
      check("R8 no valid while disabled", vcount, 0);
    end
    drive_at_posedge();
    enable = 1'b1;
    begin
      int strobes, early_high, guard;
      strobes = 0; early_high = 0; guard = 0;
      while (!pcm_valid && guard < 4 * FRAME_CYC) begin
        @(negedge clk);
        guard++;
        if (strobes == 0 && mic_clk) early_high++;
        if (frame_stb) strobes++;
      end
      check("R2 clock low until strobe", early_high, 0);
      check("R8 strobes before first valid", strobes, 2);
      check("R8 cleared filter left", int'(pcm_left), -21328);
      check("R8 cleared filter right", int'(pcm_right), -32768);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule